// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 32 peripheral interrupt request lines and offers one request to a processor. Each source has an enable bit, a pending bit and a two-bit priority level. A rising edge on a request line marks the source pending. Among the sources that are both enabled and pending, the controller picks the one with the most urgent level and presents its number together with a valid flag. The processor acknowledges the presented source, and that acknowledge clears the source's pending bit.

Software controls the block through a small word-addressed register port. Enable and pending state each have a write-one-to-set register and a write-one-to-clear register. Priority levels sit in the upper bits of byte lanes, four sources to a word. A single mask bit stops every request from reaching the processor. The outputs depend only on registered state, so they follow a register write or an acknowledge one clock later.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, enable, pending, priority and mask state are all zero, irq_valid is 0 and irq_id is 0.
- R2: Writing to word 0 sets each enable bit whose data bit is 1. Writing to word 1 clears each enable bit whose data bit is 1. Zero data bits leave the enable bits unchanged. Reading word 0 or word 1 returns the enable vector.
- R3: A 0-to-1 change on irq_lines[i] sets pending bit i whether or not source i is enabled. A line that is held high does not set the bit again after it has been cleared. The registered copy of the lines is reset to 0.
- R4: Writing to word 2 sets the pending bits whose data bits are 1. Writing to word 3 clears the pending bits whose data bits are 1. Reading word 2 or word 3 returns the pending vector.
- R5: Words 8 to 15 hold priorities. Source 4n+k uses bits [8k+7:8k+6] of word 8+n. All other bits of those words read as 0, and writes to them are ignored.
- R6: Bit 0 of word 4 is the global mask. While it is 1, irq_valid is 0 and irq_id is 0. While it is 0, arbitration proceeds as normal.
- R7: When the mask is clear and at least one source is enabled and pending, irq_valid is 1 and irq_id is the source with the lowest level value. If several sources share that level, the lowest source number wins. Otherwise irq_valid and irq_id are 0.
- R8: irq_ack, sampled while irq_valid is 1, clears the pending bit of the source on irq_id at that clock edge. A set event for the same source on the same edge takes precedence, and the bit stays 1.
- R9: Reading an unmapped word (5 to 7) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Peripheral request lines, edge sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_valid | output | 1 | A request is offered to the processor |
| irq_id | output | 5 | Number of the offered source |
| irq_ack | input | 1 | Processor takes the offered source |

## Verification
A corrupt enable or pending bit appears on irq_valid and irq_id on the clock after the bad edge, and it can also be read back through words 0 to 3 in the same cycle. A wrong priority field, or a wrong tie-break, shows up only when two candidates compete. For that reason the bench runs vectors that put sources on distinct levels, on equal levels, and at the far ends of the source numbering. Acknowledge faults show up one edge later as a request that stays on or as a lost pending bit. The case where an acknowledge and a new set event hit the same edge is checked on its own.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_EN_SET   = 4'd0;
   localparam logic [ADDR_W-1:0] A_EN_CLR   = 4'd1;
   localparam logic [ADDR_W-1:0] A_PND_SET  = 4'd2;
   localparam logic [ADDR_W-1:0] A_PND_CLR  = 4'd3;
   localparam logic [ADDR_W-1:0] A_MASK     = 4'd4;
   localparam int SRC_PER_WORD = 4;
   localparam int LANE_W = 8;
endpackage

// File: rtl/pvic_state.sv
module pvic_state #(
   parameter int N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] lines,
   input  logic             wr_en_set,
   input  logic             wr_en_clr,
   input  logic             wr_pnd_set,
   input  logic             wr_pnd_clr,
   input  logic             wr_mask,
   input  logic [N_SRC-1:0] wbits,
   input  logic [N_SRC-1:0] ack_vec,
   output logic [N_SRC-1:0] en_q,
   output logic [N_SRC-1:0] pend_q,
   output logic [N_SRC-1:0] line_q,
   output logic             mask_q
);
   logic [N_SRC-1:0] set_vec, clr_vec;

   always_comb begin
      set_vec = (lines & ~line_q) | (wr_pnd_set ? wbits : '0);
      clr_vec = ack_vec | (wr_pnd_clr ? wbits : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
         line_q <= '0;
         mask_q <= 1'b0;
      end else begin
         line_q <= lines;
         pend_q <= (pend_q & ~clr_vec) | set_vec;
         if (wr_en_set) en_q <= en_q | wbits;
         else if (wr_en_clr) en_q <= en_q & ~wbits;
         if (wr_mask) mask_q <= wbits[0];
      end
   end
endmodule

// File: rtl/pvic_prio_bank.sv
module pvic_prio_bank #(
   parameter int N_SRC = 32,
   parameter int PRIO_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [2:0]              wr_idx,
   input  logic [31:0]             wdata,
   input  logic [2:0]              rd_idx,
   output logic [31:0]             rd_data,
   output logic [N_SRC*PRIO_W-1:0] prio_flat
);
   import pvic_pkg::*;
   localparam int N_WORD = (N_SRC + SRC_PER_WORD - 1) / SRC_PER_WORD;

   logic [31:0] word_img [8];

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      localparam int LANE = g % SRC_PER_WORD;
      localparam int WIDX = g / SRC_PER_WORD;
      logic [PRIO_W-1:0] lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= '0;
         else if (wr_en && wr_idx == 3'(WIDX))
            lvl_q <= wdata[LANE_W*LANE+LANE_W-1 -: PRIO_W];
      end
      assign prio_flat[g*PRIO_W +: PRIO_W] = lvl_q;
   end

   for (genvar r = 0; r < 8; r++) begin : g_word
      always_comb begin
         word_img[r] = '0;
         for (int k = 0; k < SRC_PER_WORD; k++) begin
            if (r*SRC_PER_WORD + k < N_SRC)
               word_img[r][LANE_W*k+LANE_W-1 -: PRIO_W] =
                  prio_flat[(r*SRC_PER_WORD+k)*PRIO_W +: PRIO_W];
         end
      end
   end

   assign rd_data = (32'(rd_idx) < N_WORD) ? word_img[rd_idx] : '0;
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
   parameter int N_SRC = 32,
   parameter int PRIO_W = 2,
   localparam int ID_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]        cand,
   input  logic [N_SRC*PRIO_W-1:0] prio_flat,
   output logic                    found,
   output logic [ID_W-1:0]         win_id
);
   logic [PRIO_W-1:0] best_lvl;

   always_comb begin
      found    = 1'b0;
      win_id   = '0;
      best_lvl = '1;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (cand[i] && prio_flat[i*PRIO_W +: PRIO_W] <= best_lvl) begin
            found    = 1'b1;
            win_id   = ID_W'(i);
            best_lvl = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_SRC = 32,
   parameter int PRIO_W = 2,
   localparam int ID_W = $clog2(N_SRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [31:0]     irq_lines,
   input  logic            reg_wr,
   input  logic [3:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   output logic            irq_valid,
   output logic [ID_W-1:0] irq_id,
   input  logic            irq_ack
);
   import pvic_pkg::*;

   if (N_SRC < 2 || N_SRC > 32) begin : g_bad_src
      $error("N_SRC must lie in 2..32");
   end
   if (PRIO_W < 1 || PRIO_W > LANE_W) begin : g_bad_prio
      $error("PRIO_W must lie in 1..8");
   end

   logic [N_SRC-1:0] en_q, pend_q, line_q, ack_vec;
   logic             mask_q, found;
   logic [ID_W-1:0]  win_id;
   logic [31:0]      prio_rd;
   logic [N_SRC*PRIO_W-1:0] prio_flat;

   always_comb begin
      ack_vec = '0;
      if (irq_ack && irq_valid) ack_vec[irq_id] = 1'b1;
   end

   pvic_state #(.N_SRC(N_SRC)) i_state (
      .clk(clk), .rst_n(rst_n), .lines(irq_lines[N_SRC-1:0]),
      .wr_en_set (reg_wr && reg_addr == A_EN_SET),
      .wr_en_clr (reg_wr && reg_addr == A_EN_CLR),
      .wr_pnd_set(reg_wr && reg_addr == A_PND_SET),
      .wr_pnd_clr(reg_wr && reg_addr == A_PND_CLR),
      .wr_mask   (reg_wr && reg_addr == A_MASK),
      .wbits(reg_wdata[N_SRC-1:0]), .ack_vec(ack_vec),
      .en_q(en_q), .pend_q(pend_q), .line_q(line_q), .mask_q(mask_q)
   );

   pvic_prio_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_prio (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && reg_addr[3]), .wr_idx(reg_addr[2:0]),
      .wdata(reg_wdata), .rd_idx(reg_addr[2:0]),
      .rd_data(prio_rd), .prio_flat(prio_flat)
   );

   pvic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_arb (
      .cand(en_q & pend_q), .prio_flat(prio_flat),
      .found(found), .win_id(win_id)
   );

   assign irq_valid = found && !mask_q;
   assign irq_id    = irq_valid ? win_id : '0;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr[3]) reg_rdata = prio_rd;
      else begin
         case (reg_addr)
            A_EN_SET, A_EN_CLR:   reg_rdata = 32'(en_q);
            A_PND_SET, A_PND_CLR: reg_rdata = 32'(pend_q);
            A_MASK:               reg_rdata = {31'b0, mask_q};
            default:              reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
   parameter int N_SRC = 32,
   parameter int ID_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [31:0]      irq_lines,
   input logic             reg_wr,
   input logic [3:0]       reg_addr,
   input logic             irq_valid,
   input logic [ID_W-1:0]  irq_id,
   input logic             irq_ack,
   input logic [N_SRC-1:0] en_q,
   input logic [N_SRC-1:0] pend_q,
   input logic [N_SRC-1:0] line_q,
   input logic             mask_q
);
   logic [N_SRC-1:0] rise;
   assign rise = irq_lines[N_SRC-1:0] & ~line_q;

   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> !irq_valid && irq_id == '0); // R6
   AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> en_q[irq_id] && pend_q[irq_id]); // R7
   AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> irq_id == '0); // R7
   AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      |rise |=> (pend_q & $past(rise)) == $past(rise)); // R3
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid && irq_ack && !rise[irq_id] && !(reg_wr && reg_addr == 4'd2)
      |=> !pend_q[$past(irq_id)]); // R8
endmodule

bind prio_irq_ctrl pvic_checker #(.N_SRC(N_SRC), .ID_W(ID_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .irq_valid(irq_valid), .irq_id(irq_id),
   .irq_ack(irq_ack), .en_q(en_q), .pend_q(pend_q), .line_q(line_q),
   .mask_q(mask_q)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
   typedef struct packed {
      logic [31:0] en;
      logic [31:0] pend;
      logic [31:0] prio0;
      logic        mask;
      logic        valid;
      logic [4:0]  id;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{32'h0000_0020, 32'h0000_0020, 32'h0000_0000, 1'b0, 1'b1, 5'd5},
      '{32'h0000_000F, 32'h0000_000F, 32'h0000_0000, 1'b0, 1'b1, 5'd0},
      '{32'h0000_000F, 32'h0000_000F, 32'hC040_80C0, 1'b0, 1'b1, 5'd2},
      '{32'h0000_0009, 32'h0000_000F, 32'hC040_80C0, 1'b0, 1'b1, 5'd0},
      '{32'h0000_000F, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 5'd0},
      '{32'h0000_000F, 32'h0000_000F, 32'h0000_0000, 1'b1, 1'b0, 5'd0},
      '{32'h8000_0001, 32'h8000_0001, 32'h0000_00C0, 1'b0, 1'b1, 5'd31},
      '{32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_0000, 1'b0, 1'b1, 5'd16}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_lines = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_valid;
   logic [4:0]  irq_id;
   logic        irq_ack = 1'b0;
   int          n_chk = 0;
   int          n_err = 0;

   always #4 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_valid(irq_valid), .irq_id(irq_id), .irq_ack(irq_ack)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
      #1;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 valid", {31'b0, irq_valid}, 32'd0);
      check("R1 id", {27'b0, irq_id}, 32'd0);
      rd(4'd0, r); check("R1 enable", r, 32'd0);
      rd(4'd2, r); check("R1 pending", r, 32'd0);
      rd(4'd4, r); check("R1 mask", r, 32'd0);
      rd(4'd15, r); check("R1 prio", r, 32'd0);
      rst_n = 1'b1;

      // R7 R6 vector table
      foreach (VECS[i]) begin
         wr(4'd1, 32'hFFFF_FFFF);
         wr(4'd3, 32'hFFFF_FFFF);
         wr(4'd8, VECS[i].prio0);
         wr(4'd4, {31'b0, VECS[i].mask});
         wr(4'd0, VECS[i].en);
         wr(4'd2, VECS[i].pend);
         check($sformatf("R7 vec%0d valid", i), {31'b0, irq_valid}, {31'b0, VECS[i].valid});
         check($sformatf("R7 vec%0d id", i), {27'b0, irq_id}, {27'b0, VECS[i].id});
      end
      wr(4'd4, 32'd0);
      wr(4'd1, 32'hFFFF_FFFF);
      wr(4'd3, 32'hFFFF_FFFF);
      wr(4'd8, 32'd0);

      // R2 set/clear enable, zeros ignored
      wr(4'd0, 32'h0000_00F0);
      wr(4'd0, 32'h0);
      wr(4'd1, 32'h0);
      rd(4'd0, r); check("R2 set read", r, 32'h0000_00F0);
      wr(4'd1, 32'h0000_0030);
      rd(4'd1, r); check("R2 clr read", r, 32'h0000_00C0);

      // R4 pending set/clear
      wr(4'd2, 32'h0001_0100);
      wr(4'd3, 32'h0000_0100);
      rd(4'd3, r); check("R4 pend read", r, 32'h0001_0000);
      wr(4'd3, 32'hFFFF_FFFF);

      // R3 edge on disabled source sets pending, held level does not re-set
      @(negedge clk) irq_lines[12] = 1'b1;
      @(negedge clk);
      rd(4'd2, r); check("R3 edge sets", r, 32'h0000_1000);
      check("R3 disabled no req", {31'b0, irq_valid}, 32'd0);
      wr(4'd3, 32'h0000_1000);
      @(negedge clk);
      rd(4'd2, r); check("R3 level no reset", r, 32'd0);
      irq_lines[12] = 1'b0;

      // R5 priority lanes
      wr(4'd9, 32'hFFFF_FFFF);
      rd(4'd9, r); check("R5 lanes", r, 32'hC0C0_C0C0);
      wr(4'd9, 32'h3F7F_BF00);
      rd(4'd9, r); check("R5 fields", r, 32'h0040_8000);
      wr(4'd9, 32'd0);

      // R9 unmapped
      wr(4'd6, 32'hFFFF_FFFF);
      rd(4'd6, r); check("R9 unmapped", r, 32'd0);

      // R8 ack clears presented source
      wr(4'd1, 32'hFFFF_FFFF);
      wr(4'd0, 32'h0000_0200);
      wr(4'd2, 32'h0000_0200);
      check("R8 presented", {26'b0, irq_valid, irq_id}, {26'b0, 1'b1, 5'd9});
      @(negedge clk) irq_ack = 1'b1;
      @(negedge clk) irq_ack = 1'b0;
      #1 check("R8 ack cleared", {31'b0, irq_valid}, 32'd0);
      rd(4'd2, r); check("R8 pend clear", r, 32'd0);

      // R8 set beats ack on same edge
      wr(4'd2, 32'h0000_0200);
      @(negedge clk) begin irq_ack = 1'b1; irq_lines[9] = 1'b1; end
      @(negedge clk) irq_ack = 1'b0;
      #1 rd(4'd2, r); check("R8 set wins", r, 32'h0000_0200);
      check("R8 still valid", {31'b0, irq_valid}, 32'd1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule